// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block reads ahead from an 8-bit NAND device in the background. Software sets a transfer length, picks one of several chip selects and enables the engine through a small register bank. It then writes a start command. The engine strobes the selected device one byte at a time and stores each byte in a 64-byte FIFO. It pauses whenever the FIFO has no free byte.

The host empties the FIFO through a separate data port. Each read of that port returns one 32-bit word, made from four consecutive bytes. A status register gives the FIFO fill level and the number of bytes still to be fetched, so software can poll for data instead of waiting on strobe timing. While a transfer runs, the control register reads back as busy and the configuration registers refuse writes. A write of zero to control aborts a transfer. A following write to config1 with the enable bit clear empties the FIFO.

Top module: `nrp_prefetch`

## Requirements
- R1: The registers are addressed by byte offset: config1 at 0x1E0, config2 at 0x1E4, control at 0x1EC and status at 0x1F0. Offset 0x1E8 and any other offset read as zero. config1 holds the direction in bit 0, the enable in bit 7, a 7-bit FIFO threshold in bits 14:8 and the chip select in bits 26:24. config2 holds the byte count in bits 13:0. Both registers read back what was written.
- R2: Writing 1 to control bit 0 starts a transfer only when the enable bit in config1 is 1 and the count in config2 is nonzero. Starting empties the FIFO and makes control read 1. Otherwise the write leaves control at 0 and no strobe is issued.
- R3: While control reads 1, writes to config1 and config2 are ignored, and their readback keeps the earlier values.
- R4: While a transfer runs, exactly one active-low chip enable is driven low: the bit numbered by the chip-select field. The active-low read strobe goes low only while that enable is low. Each strobe pulse lasts exactly 2 clock cycles, and the data byte is captured on the last of them.
- R5: Bytes are packed little-endian: the first byte fetched lands in bits 7:0 of the first word. Each data-port read taken while ready is high returns the next word in fetch order.
- R6: While the FIFO holds fewer than 4 bytes, data-port ready is low, and a read request removes nothing.
- R7: No new strobe starts while the FIFO holds 64 bytes, and the fill level never exceeds 64. Fetching resumes once the host frees space.
- R8: The status register reports the FIFO fill level in bits 30:24 and the remaining byte count in bits 13:0. The remaining count drops by one for each byte fetched.
- R9: Control clears to 0 by itself when the last byte has been fetched. The number of strobe pulses equals the programmed count.
- R10: Writing 0 to control during a transfer stops it at once: no further strobes, and all chip enables go high. A following write to config1 with bit 7 clear empties the FIFO.
- R11: The direction bit in config1 is stored and read back but has no effect: a transfer with bit 0 set fetches and returns the same data as a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, valid in the same cycle |
| dp_rd | input | 1 | Data-port read request |
| dp_ready | output | 1 | At least one whole word is in the FIFO |
| dp_data | output | 32 | Word at the head of the FIFO |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_din | input | 8 | NAND data bus, input direction |

## Verification
The bound checker checks on every cycle that at most one chip enable is active, that the read strobe never goes low without an enable, that the fill level stays within 64 and nothing is pushed into a full FIFO, and that a stalled data-port read never lowers the fill level. On the same cycles it also checks that the remaining count steps by exactly one per fetched byte and that busy drops right after the final byte. The bench scenarios are needed for the rest: the byte order of the returned words, the strobe width, the register offsets, the refused writes and disabled start, the abort and flush sequence, and that the direction bit has no effect. These need a NAND data model and expected words computed from the programmed count.

// File: rtl/nrp_pkg.sv
package nrp_pkg;

  localparam logic [8:0] OFS_CFG1 = 9'h1E0;
  localparam logic [8:0] OFS_CFG2 = 9'h1E4;
  localparam logic [8:0] OFS_CTRL = 9'h1EC;
  localparam logic [8:0] OFS_STAT = 9'h1F0;

  localparam int DIR_BIT = 0;
  localparam int EN_BIT  = 7;
  localparam int THR_LSB = 8;
  localparam int CS_LSB  = 24;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOW,
    SQ_HIGH
  } seq_state_e;

  // status layout: fill level in 30:24, remaining count in 13:0
  function automatic logic [31:0] pack_status(input logic [6:0] fill,
                                              input logic [13:0] rem);
    logic [31:0] w;
    w = '0;
    w[30:24] = fill;
    w[13:0]  = rem;
    return w;
  endfunction

  function automatic logic [31:0] pack_cfg1(input logic dir, input logic en,
                                            input logic [6:0] thr,
                                            input logic [2:0] cs);
    logic [31:0] w;
    w = '0;
    w[DIR_BIT]           = dir;
    w[EN_BIT]            = en;
    w[THR_LSB +: 7]      = thr;
    w[CS_LSB +: 3]       = cs;
    return w;
  endfunction

endpackage

// File: rtl/nrp_regs.sv
module nrp_regs
  import nrp_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CNT_W  = 14,
  parameter int FILL_W = 7,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [8:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              byte_pushed,
  input  logic [FILL_W-1:0] fill,
  output logic              busy,
  output logic [CS_W-1:0]   cs_sel,
  output logic [CNT_W-1:0]  remaining,
  output logic              flush
);

  logic             dir_q, en_q;
  logic [6:0]       thr_q;
  logic [CS_W-1:0]  cs_q;
  logic [CNT_W-1:0] cnt_q, rem_q;
  logic             busy_q;

  logic wr_cfg1, wr_cfg2, start_ev, stop_ev, last_ev;

  assign wr_cfg1  = reg_wr && reg_addr == OFS_CFG1 && !busy_q;
  assign wr_cfg2  = reg_wr && reg_addr == OFS_CFG2 && !busy_q;
  assign start_ev = reg_wr && reg_addr == OFS_CTRL && reg_wdata[0] && !busy_q
                    && en_q && cnt_q != '0;
  assign stop_ev  = reg_wr && reg_addr == OFS_CTRL && !reg_wdata[0] && busy_q;
  assign last_ev  = busy_q && byte_pushed && rem_q == CNT_W'(1);
  assign flush    = start_ev || (wr_cfg1 && !reg_wdata[EN_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
      thr_q  <= '0;
      cs_q   <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr_cfg1) begin
        dir_q <= reg_wdata[DIR_BIT];
        en_q  <= reg_wdata[EN_BIT];
        thr_q <= reg_wdata[THR_LSB +: 7];
        cs_q  <= reg_wdata[CS_LSB +: CS_W];
      end
      if (wr_cfg2) cnt_q <= reg_wdata[CNT_W-1:0];
      if (start_ev) begin
        busy_q <= 1'b1;
        rem_q  <= cnt_q;
      end else begin
        if (busy_q && byte_pushed) rem_q <= rem_q - CNT_W'(1);
        if (stop_ev || last_ev) busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CFG1: reg_rdata = pack_cfg1(dir_q, en_q, thr_q, 3'(cs_q));
      OFS_CFG2: reg_rdata = 32'(cnt_q);
      OFS_CTRL: reg_rdata = {31'b0, busy_q};
      OFS_STAT: reg_rdata = pack_status(7'(fill), 14'(rem_q));
      default:  reg_rdata = '0;
    endcase
  end

  assign busy      = busy_q;
  assign cs_sel    = cs_q;
  assign remaining = rem_q;

endmodule

// File: rtl/nrp_seq.sv
module nrp_seq
  import nrp_pkg::*;
#(
  parameter int NUM_CS      = 8,
  parameter int RE_LOW_CYC  = 2,
  parameter int RE_HIGH_CYC = 2,
  localparam int CS_W       = $clog2(NUM_CS),
  localparam int TMR_MAX    = (RE_LOW_CYC > RE_HIGH_CYC) ? RE_LOW_CYC : RE_HIGH_CYC,
  localparam int TMR_W      = $clog2(TMR_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rem_nz,
  input  logic              room,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [7:0]        nand_din,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_re_n,
  output logic              push,
  output logic [7:0]        push_byte
);

  seq_state_e       st_q;
  logic [TMR_W-1:0] tmr_q;
  logic             low_done, high_done;

  assign low_done  = tmr_q == TMR_W'(RE_LOW_CYC - 1);
  assign high_done = tmr_q == TMR_W'(RE_HIGH_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (run && rem_nz && room) begin
          st_q  <= SQ_LOW;
          tmr_q <= '0;
        end
        SQ_LOW: begin
          if (!run) begin
            st_q <= SQ_IDLE;
          end else if (low_done) begin
            st_q  <= SQ_HIGH;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        SQ_HIGH: begin
          if (high_done) st_q <= SQ_IDLE;
          else           tmr_q <= tmr_q + TMR_W'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign nand_re_n = !(st_q == SQ_LOW && run);
  assign push      = st_q == SQ_LOW && run && low_done;
  assign push_byte = nand_din;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign nand_ce_n[g] = !(run && cs_sel == CS_W'(g));
  end

endmodule

// File: rtl/nrp_fifo.sv
module nrp_fifo #(
  parameter int DEPTH   = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic              pop,
  output logic [FILL_W-1:0] fill,
  output logic [31:0]       head_word,
  output logic              room,
  output logic              word_avail
);

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [FILL_W-1:0] fill_q;

  // one byte in, one four-byte word out per cycle
  function automatic logic [FILL_W-1:0] fill_step(input logic [FILL_W-1:0] f,
                                                  input logic in_b, input logic out_w);
    return f + FILL_W'(in_b) - (out_w ? FILL_W'(4) : FILL_W'(0));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_byte;
        wr_ptr      <= wr_ptr + PTR_W'(1);
      end
      if (pop) rd_ptr <= rd_ptr + PTR_W'(4);
      fill_q <= fill_step(fill_q, push, pop);
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [PTR_W-1:0] lane_ptr;
    assign lane_ptr            = rd_ptr + PTR_W'(g);
    assign head_word[8*g +: 8] = mem[lane_ptr];
  end

  assign fill       = fill_q;
  assign room       = fill_q < FILL_W'(DEPTH);
  assign word_avail = fill_q >= FILL_W'(4);

endmodule

// File: rtl/nrp_prefetch.sv
module nrp_prefetch #(
  parameter int NUM_CS      = 8,
  parameter int FIFO_BYTES  = 64,
  parameter int CNT_W       = 14,
  parameter int RE_LOW_CYC  = 2,
  parameter int RE_HIGH_CYC = 2,
  localparam int CS_W       = $clog2(NUM_CS),
  localparam int FILL_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [8:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dp_rd,
  output logic              dp_ready,
  output logic [31:0]       dp_data,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_re_n,
  input  logic [7:0]        nand_din
);

  // named internal events, also watched by the bound checker
  logic              busy;
  logic              flush;
  logic              byte_push;
  logic [7:0]        byte_val;
  logic              word_pop;
  logic              fifo_room;
  logic [FILL_W-1:0] fifo_fill;
  logic [CS_W-1:0]   cs_sel;
  logic [CNT_W-1:0]  remaining;

  assign word_pop = dp_rd && dp_ready;

  nrp_regs #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .FILL_W(FILL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .byte_pushed(byte_push),
    .fill       (fifo_fill),
    .busy       (busy),
    .cs_sel     (cs_sel),
    .remaining  (remaining),
    .flush      (flush)
  );

  nrp_seq #(.NUM_CS(NUM_CS), .RE_LOW_CYC(RE_LOW_CYC), .RE_HIGH_CYC(RE_HIGH_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .rem_nz   (remaining != '0),
    .room     (fifo_room),
    .cs_sel   (cs_sel),
    .nand_din (nand_din),
    .nand_ce_n(nand_ce_n),
    .nand_re_n(nand_re_n),
    .push     (byte_push),
    .push_byte(byte_val)
  );

  nrp_fifo #(.DEPTH(FIFO_BYTES)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (byte_push),
    .push_byte (byte_val),
    .pop       (word_pop),
    .fill      (fifo_fill),
    .head_word (dp_data),
    .room      (fifo_room),
    .word_avail(dp_ready)
  );

endmodule

// File: rtl/nrp_prefetch_chk.sv
module nrp_prefetch_chk #(
  parameter int NUM_CS     = 8,
  parameter int FIFO_BYTES = 64,
  parameter int CNT_W      = 14,
  parameter int FILL_W     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              dp_rd,
  input logic              dp_ready,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_re_n,
  input logic [FILL_W-1:0] fill,
  input logic              busy,
  input logic              push,
  input logic [CNT_W-1:0]  rem
);

  p_one_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  p_strobe_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (nand_ce_n != '1));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(FIFO_BYTES));

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FILL_W'(FIFO_BYTES)) |-> !push);

  p_stall_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rd && !dp_ready && !reg_wr) |=> fill >= $past(fill));

  p_rem_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && push) |=> rem == $past(rem) - CNT_W'(1));

  p_rem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !push) |=> rem == $past(rem));

  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && push && rem == CNT_W'(1)) |=> !busy);

endmodule

bind nrp_prefetch nrp_prefetch_chk #(
  .NUM_CS(NUM_CS), .FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W), .FILL_W(FILL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .dp_rd    (dp_rd),
  .dp_ready (dp_ready),
  .nand_ce_n(nand_ce_n),
  .nand_re_n(nand_re_n),
  .fill     (fifo_fill),
  .busy     (busy),
  .push     (byte_push),
  .rem      (remaining)
);

// File: tb/nrp_prefetch_tb.sv
module nrp_prefetch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [8:0] A_CFG1 = 9'h1E0, A_CFG2 = 9'h1E4, A_RSVD = 9'h1E8,
                         A_CTRL = 9'h1EC, A_STAT = 9'h1F0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dp_rd = 1'b0;
  logic        dp_ready;
  logic [31:0] dp_data;
  logic [7:0]  nand_ce_n;
  logic        nand_re_n;
  logic [7:0]  nand_din;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int idx = 0, pulses = 0, ce_err = 0, width_err = 0, low_run = 0, exp_cs = 0, k = 0;
  logic [7:0] base = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrp_prefetch u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_rd(dp_rd),
    .dp_ready(dp_ready), .dp_data(dp_data), .nand_ce_n(nand_ce_n),
    .nand_re_n(nand_re_n), .nand_din(nand_din)
  );

  function automatic logic [7:0] byte_at(input logic [7:0] b, input int i);
    return 8'(b + i * 37 + (i >> 3));
  endfunction

  function automatic logic [31:0] word_at(input logic [7:0] b, input int w);
    return {byte_at(b, 4*w+3), byte_at(b, 4*w+2), byte_at(b, 4*w+1), byte_at(b, 4*w)};
  endfunction

  // NAND model: each completed strobe moves on to the next byte
  assign nand_din = byte_at(base, idx);
  always @(posedge nand_re_n) begin
    idx++;
    pulses++;
  end

  // strobe width and chip-enable observer
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_re_n) begin
        low_run++;
        if (nand_ce_n !== ~(8'(1) << exp_cs)) ce_err++;
      end else if (low_run != 0) begin
        if (low_run != 2) width_err++;
        low_run = 0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg1_val(input int cs, input bit en, input bit dir);
    return (32'(cs) << 24) | (32'h40 << 8) | (32'(en) << 7) | 32'(dir);
  endfunction

  task automatic start_xfer(input int n, input int cs, input bit dir);
    base = 8'($urandom); idx = 0; pulses = 0; ce_err = 0; width_err = 0; k = 0;
    exp_cs = cs;
    reg_write(A_CFG1, cfg1_val(cs, 1'b1, dir));
    reg_write(A_CFG2, 32'(n));
    reg_write(A_CTRL, 32'd1);
  endtask

  // pop words (every ready cycle, or at random) until idle and no whole word is left
  task automatic drain(input bit rnd);
    bit busy_s, rdy;
    forever begin
      @(negedge clk);
      reg_addr = A_CTRL;
      #1;
      busy_s = reg_rdata[0];
      rdy = dp_ready;
      if (!busy_s && !rdy) begin
        dp_rd = 1'b0;
        break;
      end
      if (rdy && (!rnd || ($urandom % 3) != 0)) begin
        dp_rd = 1'b1;
        check(dp_data == word_at(base, k), "R5 word order", dp_data, word_at(base, k));
        k++;
      end else begin
        dp_rd = 1'b0;
      end
    end
  endtask

  task automatic finish_checks(input int n, input string tag);
    logic [31:0] st;
    check(k == n / 4, {tag, " R5 word count"}, 32'(k), 32'(n / 4));
    check(pulses == n, {tag, " R9 strobe count"}, 32'(pulses), 32'(n));
    check(ce_err == 0 && width_err == 0, {tag, " R4 strobe/enable"},
          32'(ce_err + width_err), 32'd0);
    reg_read(A_STAT, st);
    check(st == (32'(n % 4) << 24), {tag, " R8 final status"}, st, 32'(n % 4) << 24);
  endtask

  initial begin
    logic [31:0] rd;
    int p0;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0; idx = 0;

    // reset state
    reg_read(A_CTRL, rd);
    check(rd == 0, "R2 reset control", rd, 0);
    reg_read(A_STAT, rd);
    check(rd == 0, "R8 reset status", rd, 0);
    check({nand_ce_n, nand_re_n, dp_ready} == {8'hFF, 1'b1, 1'b0}, "R4 reset pins",
          32'({nand_ce_n, nand_re_n, dp_ready}), 32'({8'hFF, 1'b1, 1'b0}));

    // R1: register fields and readback
    reg_write(A_CFG1, cfg1_val(5, 1'b0, 1'b1) | 32'hE0FF_8000);
    reg_read(A_CFG1, rd);
    check(rd == 32'h0500_4001, "R1 config1 readback", rd, 32'h0500_4001);
    reg_write(A_CFG2, 32'hFFFF_2345);
    reg_read(A_CFG2, rd);
    check(rd == 32'h2345, "R1 config2 readback", rd, 32'h2345);
    reg_write(A_RSVD, 32'hFFFF_FFFF);
    reg_read(A_RSVD, rd);
    check(rd == 0, "R1 reserved offset", rd, 0);

    // R2: start with enable clear is ignored
    reg_write(A_CFG2, 32'd8);
    reg_write(A_CTRL, 32'd1);
    repeat (20) @(negedge clk);
    reg_read(A_CTRL, rd);
    check(rd == 0 && pulses == 0, "R2 start without enable", rd, 0);

    // directed transfer with full drain
    start_xfer(16, 2, 1'b0);
    reg_read(A_CTRL, rd);
    check(rd == 1, "R2 control busy after start", rd, 1);
    drain(1'b0);
    finish_checks(16, "d16");

    // R6: partial word stalls
    start_xfer(6, 7, 1'b0);
    drain(1'b0);
    finish_checks(6, "d6");
    @(negedge clk); dp_rd = 1'b1;
    repeat (3) @(negedge clk);
    dp_rd = 1'b0;
    reg_read(A_STAT, rd);
    check(rd[30:24] == 2 && !dp_ready, "R6 stalled read keeps bytes", rd, 32'h0200_0000);

    // R7 and R8: FIFO fills and fetching pauses
    start_xfer(100, 0, 1'b0);
    while (pulses < 64) @(negedge clk);
    repeat (40) @(negedge clk);
    check(pulses == 64, "R7 no strobe while full", 32'(pulses), 64);
    reg_read(A_STAT, rd);
    check(rd == ((32'd64 << 24) | 32'd36), "R8 status when full", rd,
          (32'd64 << 24) | 32'd36);
    reg_read(A_CTRL, rd);
    check(rd == 1, "R9 still busy while paused", rd, 1);
    drain(1'b1);
    finish_checks(100, "full100");

    // R3 and R10: lockout, abort, flush
    start_xfer(200, 3, 1'b0);
    reg_write(A_CFG2, 32'd5);
    reg_write(A_CFG1, cfg1_val(6, 1'b1, 1'b0));
    reg_read(A_CFG2, rd);
    check(rd == 200, "R3 config2 locked", rd, 200);
    reg_read(A_CFG1, rd);
    check(rd == cfg1_val(3, 1'b1, 1'b0), "R3 config1 locked", rd, cfg1_val(3, 1'b1, 1'b0));
    while (pulses < 10) @(negedge clk);
    reg_write(A_CTRL, 32'd0);
    p0 = pulses;
    reg_read(A_CTRL, rd);
    check(rd == 0, "R10 abort clears control", rd, 0);
    repeat (20) @(negedge clk);
    check(pulses == p0 && nand_re_n && nand_ce_n == 8'hFF, "R10 no strobes after abort",
          32'(pulses), 32'(p0));
    reg_read(A_STAT, rd);
    check(rd[30:24] != 0, "R10 bytes kept before flush", rd, 32'h0A00_0000);
    reg_write(A_CFG1, 32'd0);
    reg_read(A_STAT, rd);
    check(rd[30:24] == 0 && !dp_ready, "R10 flush empties FIFO", rd, 32'(rd[13:0]));
    check(ce_err == 0 && width_err == 0, "R4 enable during abort", 32'(ce_err), 0);

    // R11: direction bit ignored
    start_xfer(32, 1, 1'b1);
    reg_read(A_CFG1, rd);
    check(rd[0] == 1'b1, "R11 direction bit stored", rd, cfg1_val(1, 1'b1, 1'b1));
    drain(1'b1);
    finish_checks(32, "R11 dir1");

    // random transfers with random drain
    for (int t = 0; t < 6; t++) begin
      int n;
      n = $urandom_range(1, 160);
      start_xfer(n, $urandom_range(0, 7), 1'($urandom));
      drain(1'b1);
      finish_checks(n, "rand R5");
    end

    summary();
    $finish;
  end

endmodule